// File: doc/BRIEF.md
# Time-Triggered Message Timer

This block is the time base of a time-triggered CAN controller. It holds three counters: a network timer, a cycle time counter, and a 6-bit cycle count. All three advance on an external timer tick while the block is enabled. The cycle time returns to zero after it reaches a programmable cycle length, and each such return increments the cycle count.

The block builds two 16-bit timestamps. The first is for the low-numbered mailboxes (1 to 15), and a control bit selects how it is formed. The second is for the two reserved top mailboxes (30 and 31) and is always the plain cycle time.

A compare register is checked against the cycle time. A match can raise a sticky interrupt flag. When both enable bits allow it and the controller is not halted, a match can also cancel every pending transmission at once, using a one-cycle cancel mask that the surrounding logic ORs into its cancel-request register.

Top module: `tt_timebase`

## Requirements
- R1: While the run bit (control bit 0) is 0, the network timer, cycle time and cycle count are held at 0 and ignore ticks. All four control bits reset to 0.
- R2: While running, each cycle with `tick` high advances the network timer and the cycle time by one. Cycles with `tick` low change neither.
- R3: The cycle time counts from 0 up to the cycle length and then returns to 0 on the next tick. The cycle count increments on every return and wraps from 63 to 0. A cycle length of 0 makes every tick a return.
- R4: With the stamp select bit (control bit 1) at 0, `ts_low` equals the cycle time.
- R5: With the stamp select bit at 1, `ts_low` is the cycle count in bits 15:10, followed by cycle time bits 15:6 in bits 9:0.
- R6: `ts_high` equals the cycle time whatever the stamp select bit is.
- R7: With the compare-interrupt bit (control bit 3) at 1, a tick that brings the cycle time to the compare value sets `irq_flag`. With that bit at 0, a match never sets it.
- R8: `irq_flag` stays set until a cycle with `irq_clr` high clears it. If a new match arrives in the same cycle as the clear, the flag stays set.
- R9: A cancel pulse is issued only on a match while the cancel bit (control bit 2) and the compare-interrupt bit are both 1 and `halt` is 0. The pulse lasts exactly one cycle.
- R10: The cancel mask of a pulse equals `tx_pend` as sampled at the match. Outside a pulse the mask is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 4 | Control bits: 0 run, 1 stamp select, 2 cancel enable, 3 compare-interrupt enable |
| len_we | input | 1 | Cycle length write strobe |
| len_wdata | input | 16 | Cycle length (last value before the return to 0) |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_wdata | input | 16 | Compare value |
| tick | input | 1 | Timer tick enable |
| halt | input | 1 | Controller halted; suppresses cancellation |
| tx_pend | input | 32 | Pending-transmit bit per mailbox |
| irq_clr | input | 1 | Clears the interrupt flag |
| net_time | output | 16 | Network timer |
| cyc_time | output | 16 | Cycle time |
| cyc_count | output | 6 | Cycle count |
| ts_low | output | 16 | Timestamp for mailboxes 1 to 15 |
| ts_high | output | 16 | Timestamp for mailboxes 30 and 31 |
| irq_flag | output | 1 | Sticky compare interrupt flag |
| cancel_mask | output | 32 | One-cycle transmit-cancel request mask |

## Verification
The counters are run with the tick held low and held high, and with a short cycle length, a zero cycle length and a long one. These separate counting from wrapping and show the cycle count rolling past 63. Both timestamp forms are read at a point where the cycle count and the upper cycle-time bits are nonzero, so a swapped or misaligned field shows up. The compare path is tried with every combination of the two enable bits and with `halt` high and low. Each cycle around the match is checked, so a missing gate, a repeated pulse or a mask that does not follow `tx_pend` is reported.

// File: rtl/tt_pkg.sv
package tt_pkg;
  // Bit order follows the control write word: [3] irq, [2] cancel, [1] packed stamp, [0] run
  typedef struct packed {
    logic irq_en;
    logic cancel_en;
    logic packed_ts;
    logic run;
  } tt_ctl_t;

  localparam int CTL_W = $bits(tt_ctl_t);
endpackage

// File: rtl/tt_cycle_timer.sv
module tt_cycle_timer #(
  parameter int CYC_W = 16,
  parameter int CNT_W = 6,
  parameter int NET_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CYC_W-1:0] cyc_len,
  output logic [NET_W-1:0] net_q,
  output logic [CYC_W-1:0] cyc_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CYC_W-1:0] cyc_nxt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             step
);
  logic [NET_W-1:0] net_nxt;
  logic             at_end;

  assign step   = run & tick;
  assign at_end = (cyc_q == cyc_len);

  always_comb begin
    net_nxt = net_q;
    cyc_nxt = cyc_q;
    cnt_nxt = cnt_q;
    if (!run) begin
      net_nxt = '0;
      cyc_nxt = '0;
      cnt_nxt = '0;
    end else if (tick) begin
      net_nxt = net_q + 1'b1;
      if (at_end) begin
        cyc_nxt = '0;
        cnt_nxt = cnt_q + 1'b1;
      end else begin
        cyc_nxt = cyc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      net_q <= '0;
      cyc_q <= '0;
      cnt_q <= '0;
    end else begin
      net_q <= net_nxt;
      cyc_q <= cyc_nxt;
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/tt_stamp_mux.sv
module tt_stamp_mux #(
  parameter int CYC_W = 16,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             packed_sel,
  input  logic [CYC_W-1:0] cyc_nxt,
  input  logic [CNT_W-1:0] cnt_nxt,
  output logic [CYC_W-1:0] ts_low,
  output logic [CYC_W-1:0] ts_high
);
  localparam int HI_W = CYC_W - CNT_W;

  logic [CYC_W-1:0] packed_val;
  assign packed_val = {cnt_nxt, cyc_nxt[CYC_W-1 -: HI_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ts_low  <= '0;
      ts_high <= '0;
    end else begin
      ts_low  <= packed_sel ? packed_val : cyc_nxt;
      ts_high <= cyc_nxt;
    end
  end
endmodule

// File: rtl/tt_cmp_cancel.sv
module tt_cmp_cancel #(
  parameter int CYC_W = 16,
  parameter int MBX_N = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [CYC_W-1:0] cyc_nxt,
  input  logic [CYC_W-1:0] cmp_val,
  input  logic             irq_en,
  input  logic             cancel_en,
  input  logic             halt,
  input  logic [MBX_N-1:0] tx_pend,
  input  logic             irq_clr,
  output logic             irq_flag,
  output logic [MBX_N-1:0] cancel_mask
);
  logic hit;
  logic do_cancel;

  // Match only on the tick that moves the cycle time onto the compare value
  assign hit       = step & (cyc_nxt == cmp_val) & irq_en;
  assign do_cancel = hit & cancel_en & ~halt;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_flag    <= 1'b0;
      cancel_mask <= '0;
    end else begin
      if (hit)          irq_flag <= 1'b1;
      else if (irq_clr) irq_flag <= 1'b0;
      cancel_mask <= do_cancel ? tx_pend : '0;
    end
  end
endmodule

// File: rtl/tt_timebase.sv
module tt_timebase #(
  parameter int CYC_W = 16,
  parameter int CNT_W = 6,
  parameter int NET_W = 16,
  parameter int MBX_N = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [tt_pkg::CTL_W-1:0] cfg_wdata,
  input  logic                    len_we,
  input  logic [CYC_W-1:0]        len_wdata,
  input  logic                    cmp_we,
  input  logic [CYC_W-1:0]        cmp_wdata,
  input  logic                    tick,
  input  logic                    halt,
  input  logic [MBX_N-1:0]        tx_pend,
  input  logic                    irq_clr,
  output logic [NET_W-1:0]        net_time,
  output logic [CYC_W-1:0]        cyc_time,
  output logic [CNT_W-1:0]        cyc_count,
  output logic [CYC_W-1:0]        ts_low,
  output logic [CYC_W-1:0]        ts_high,
  output logic                    irq_flag,
  output logic [MBX_N-1:0]        cancel_mask
);
  import tt_pkg::*;

  tt_ctl_t          ctl_q, ctl_nxt;
  logic [CYC_W-1:0] len_q, cmp_q;
  logic [CYC_W-1:0] cyc_nxt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             step;
  logic             run_on;

  assign ctl_nxt = cfg_we ? tt_ctl_t'(cfg_wdata) : ctl_q;
  assign run_on  = ctl_q.run;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      len_q <= '1;
      cmp_q <= '0;
    end else begin
      ctl_q <= ctl_nxt;
      if (len_we) len_q <= len_wdata;
      if (cmp_we) cmp_q <= cmp_wdata;
    end
  end

  tt_cycle_timer #(.CYC_W(CYC_W), .CNT_W(CNT_W), .NET_W(NET_W)) u_timer (
    .clk(clk), .rst(rst), .run(run_on), .tick(tick), .cyc_len(len_q),
    .net_q(net_time), .cyc_q(cyc_time), .cnt_q(cyc_count),
    .cyc_nxt(cyc_nxt), .cnt_nxt(cnt_nxt), .step(step)
  );

  tt_stamp_mux #(.CYC_W(CYC_W), .CNT_W(CNT_W)) u_stamp (
    .clk(clk), .rst(rst), .packed_sel(ctl_nxt.packed_ts),
    .cyc_nxt(cyc_nxt), .cnt_nxt(cnt_nxt),
    .ts_low(ts_low), .ts_high(ts_high)
  );

  tt_cmp_cancel #(.CYC_W(CYC_W), .MBX_N(MBX_N)) u_cmp (
    .clk(clk), .rst(rst), .step(step), .cyc_nxt(cyc_nxt), .cmp_val(cmp_q),
    .irq_en(ctl_q.irq_en), .cancel_en(ctl_q.cancel_en), .halt(halt),
    .tx_pend(tx_pend), .irq_clr(irq_clr),
    .irq_flag(irq_flag), .cancel_mask(cancel_mask)
  );
endmodule

// File: rtl/tt_timebase_chk.sv
module tt_timebase_chk #(
  parameter int CYC_W = 16,
  parameter int CNT_W = 6,
  parameter int NET_W = 16,
  parameter int MBX_N = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             run_on,
  input logic             halt,
  input logic             irq_clr,
  input logic [MBX_N-1:0] tx_pend,
  input logic [NET_W-1:0] net_time,
  input logic [CYC_W-1:0] cyc_time,
  input logic [CNT_W-1:0] cyc_count,
  input logic [CYC_W-1:0] ts_high,
  input logic             irq_flag,
  input logic [MBX_N-1:0] cancel_mask
);
  AST_STOPPED_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !run_on |=> (net_time == '0 && cyc_time == '0 && cyc_count == '0)); // R1

  AST_HIGH_STAMP: assert property (@(posedge clk) disable iff (rst)
    ts_high == cyc_time); // R6

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !irq_clr) |=> irq_flag); // R8

  AST_CANCEL_NOT_HALTED: assert property (@(posedge clk) disable iff (rst)
    (|cancel_mask) |-> (!$past(halt) && irq_flag)); // R9

  AST_CANCEL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (|cancel_mask) |=> (cancel_mask == '0)); // R9

  AST_CANCEL_SUBSET: assert property (@(posedge clk) disable iff (rst)
    (|cancel_mask) |-> ((cancel_mask & ~$past(tx_pend)) == '0)); // R10
endmodule

bind tt_timebase tt_timebase_chk #(
  .CYC_W(CYC_W), .CNT_W(CNT_W), .NET_W(NET_W), .MBX_N(MBX_N)
) u_chk (
  .clk(clk), .rst(rst), .run_on(run_on), .halt(halt), .irq_clr(irq_clr),
  .tx_pend(tx_pend), .net_time(net_time), .cyc_time(cyc_time),
  .cyc_count(cyc_count), .ts_high(ts_high), .irq_flag(irq_flag),
  .cancel_mask(cancel_mask)
);

// File: tb/tt_timebase_bench.sv
`timescale 1ns/1ps
module tt_timebase_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_wdata = '0;
  logic        len_we = 1'b0;
  logic [15:0] len_wdata = '0;
  logic        cmp_we = 1'b0;
  logic [15:0] cmp_wdata = '0;
  logic        tick = 1'b0;
  logic        halt = 1'b0;
  logic [31:0] tx_pend = '0;
  logic        irq_clr = 1'b0;
  logic [15:0] net_time, cyc_time, ts_low, ts_high;
  logic [5:0]  cyc_count;
  logic        irq_flag;
  logic [31:0] cancel_mask;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tt_timebase u_tt_timebase (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .len_we(len_we), .len_wdata(len_wdata), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .tick(tick), .halt(halt), .tx_pend(tx_pend), .irq_clr(irq_clr),
    .net_time(net_time), .cyc_time(cyc_time), .cyc_count(cyc_count),
    .ts_low(ts_low), .ts_high(ts_high), .irq_flag(irq_flag), .cancel_mask(cancel_mask)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [3:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // Stop, load length and compare, then start with cfg; returns with cycle time 0
  task automatic restart(input logic [15:0] len, input logic [15:0] cmpv, input logic [3:0] cfg);
    write_cfg(4'b0000);
    len_we = 1'b1; len_wdata = len; cmp_we = 1'b1; cmp_wdata = cmpv;
    @(negedge clk); len_we = 1'b0; cmp_we = 1'b0;
    write_cfg(cfg);
  endtask

  task automatic t_reset;
    chk("R1 reset cyc", cyc_time, 0);
    chk("R1 reset net", net_time, 0);
    chk("R1 reset cnt", cyc_count, 0);
    chk("R1 reset irq", irq_flag, 0);
    chk("R10 reset mask", cancel_mask, 0);
    tick = 1'b1;
    step(8);
    chk("R1 disabled ignores tick", cyc_time, 0);
    chk("R1 disabled net", net_time, 0);
  endtask

  task automatic t_count;
    tick = 1'b0;
    restart(16'hFFFF, 16'h0, 4'b0001);
    step(5);
    chk("R2 no tick holds", cyc_time, 0);
    tick = 1'b1;
    step(7);
    chk("R2 cyc counts", cyc_time, 7);
    chk("R2 net counts", net_time, 7);
  endtask

  task automatic t_wrap;
    restart(16'd4, 16'h0, 4'b0001);
    step(12);
    chk("R3 wrap cyc", cyc_time, 12 % 5);
    chk("R3 wrap cnt", cyc_count, 12 / 5);
    chk("R3 net through wrap", net_time, 12);
    restart(16'd0, 16'h0, 4'b0001);
    step(70);
    chk("R3 len0 cyc", cyc_time, 0);
    chk("R3 cnt rolls 63->0", cyc_count, 70 % 64);
    write_cfg(4'b0000);
    step(2);
    chk("R1 stop clears cnt", cyc_count, 0);
    chk("R1 stop clears net", net_time, 0);
  endtask

  task automatic t_stamp;
    logic [15:0] e;
    restart(16'hFFFF, 16'h0, 4'b0001);
    step(300);
    chk("R4 plain stamp", ts_low, 300);
    chk("R6 high stamp plain", ts_high, 300);
    restart(16'h07FF, 16'h0, 4'b0011);
    step(5000);
    chk("R3 long cyc", cyc_time, 5000 % 2048);
    chk("R3 long cnt", cyc_count, 2);
    e = {6'd2, 10'((5000 % 2048) >> 6)};
    chk("R5 packed stamp", ts_low, e);
    chk("R6 high stamp packed", ts_high, 5000 % 2048);
  endtask

  task automatic t_irq;
    restart(16'hFFFF, 16'd10, 4'b1001);
    step(9);
    chk("R7 before match", irq_flag, 0);
    step(1);
    chk("R7 at match cyc", cyc_time, 10);
    chk("R7 match sets irq", irq_flag, 1);
    chk("R9 no cancel without enable", cancel_mask, 0);
    step(4);
    chk("R8 sticky", irq_flag, 1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    chk("R8 cleared", irq_flag, 0);
    restart(16'hFFFF, 16'd10, 4'b0001);
    step(15);
    chk("R7 disabled no irq", irq_flag, 0);
  endtask

  task automatic t_cancel(input logic [31:0] pend, input logic h, input logic [3:0] cfg,
                          input bit expect_pulse, input string tag);
    int hits;
    hits = 0;
    tx_pend = pend;
    halt = h;
    restart(16'hFFFF, 16'd6, cfg);
    for (int i = 1; i <= 12; i++) begin
      step(1);
      if (cyc_time == 16'd6 && expect_pulse) begin
        chk({tag, " R10 mask at match"}, cancel_mask, pend);
        hits++;
      end else begin
        chk({tag, " R9 mask idle"}, cancel_mask, 0);
      end
    end
    if (expect_pulse) chk({tag, " R9 single pulse"}, hits, 1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    halt = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_count();
    t_wrap();
    t_stamp();
    t_irq();
    t_cancel(32'h8000_A50E, 1'b0, 4'b1101, 1, "cancel");
    t_cancel(32'h0000_0003, 1'b0, 4'b1101, 1, "cancel2");
    t_cancel(32'hFFFF_FFFF, 1'b1, 4'b1101, 0, "halted");
    t_cancel(32'hFFFF_FFFF, 1'b0, 4'b0101, 0, "no_irq_en");
    t_cancel(32'hFFFF_FFFF, 1'b0, 4'b1001, 0, "no_cancel_en");
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule